// File: doc/BRIEF.md
# Holding Round-Robin Arbiter

This block shares one resource among a fixed number of requesters, nine by default. Each requester drives one bit of a request vector. The block answers in the same cycle with a grant vector that has at most one bit set. A registered pointer marks the requester that currently has top priority. A rotate, fixed-pick, rotate-back encoder chooses the first active requester found by walking circularly from that pointer.

A requester that wins keeps the grant for as long as it keeps its request raised. The pointer is loaded with the winner's index at each clock edge. When the winner lets go, the grant moves to the nearest active requester after it in circular order. If no requester is active, the pointer falls back to position 0. The number of requesters is a parameter and need not be a power of two.

Top module: `hold_rr_arbiter`

## Requirements
- R1: At most one bit of `gnt_o` is high in any cycle.
- R2: A grant bit is only high while the matching request bit is high. Whenever any request bit is high, some grant bit is high in that same cycle.
- R3: Bit i of `req_i` and `gnt_o` belongs to requester i. The granted requester is the first one with its request high, searching p, p+1, … N-1, 0, 1, … from the pointer position p.
- R4: If the requester at the pointer is idle but others are active, the grant skips to the next active one in the same cycle. At the following clock edge the pointer takes the granted requester's index.
- R5: A requester that holds its request keeps the grant on every following cycle, whatever the other requests do.
- R6: When the grantee drops its request while others are active, the grant goes to the first active requester after the former grantee in circular order.
- R7: In a cycle with no request high, `gnt_o` is all zeros and the pointer returns to position 0 at the next edge.
- R8: After reset (`rst_ni` low) the pointer is 0, so requester 0 has top priority on the first arbitration.
- R9: When every requester keeps requesting and each releases once after its grant, grants are handed out in index order 0,1,…,N-1,0. No requester waits more than N-1 turns.
- R10: The pointer always stays in the range 0 to N-1 and wraps from N-1 to 0, for any N including non-powers of two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; the pointer updates on the rising edge |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_i | input | N | Request bit per requester |
| gnt_o | output | N | One-hot (or zero) grant, combinational from `req_i` and the pointer |

## Verification
The bench first sets the pointer to each position in turn by granting a single requester. At each position it applies all 2^N request vectors and compares the grant with a circular first-set search. This separates a correct rotation from an off-by-one or a missing wrap. After each vector, an all-ones request shows where the pointer moved, which tells "load the grantee" apart from "stay" or "increment". Directed sequences cover a holder that keeps its grant while every other bit is set, release to the next requester, and a return to 0 after an idle cycle; that idle case tells pointer clearing apart from pointer holding. A full release rotation checks the index-order fairness.

// File: rtl/hrr_pkg.sv
package hrr_pkg;

    // Width of a pointer that must address n positions (at least one bit).
    function automatic int unsigned ptr_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Circular position a + b within a ring of n slots.
    function automatic int unsigned ring_add(input int unsigned a, input int unsigned b,
                                             input int unsigned n);
        return (a + b) % n;
    endfunction

    // Circular position a - b within a ring of n slots (b < n).
    function automatic int unsigned ring_sub(input int unsigned a, input int unsigned b,
                                             input int unsigned n);
        return (a + n - b) % n;
    endfunction

endpackage

// File: rtl/hrr_rotate.sv
// Circular rotation by a run-time amount that may be any value 0..N-1.
// UNDO = 0 : out[i] = in[(i + amt) mod N]   (pointer slot moves to bit 0)
// UNDO = 1 : out[i] = in[(i - amt) mod N]   (bit 0 moves back to pointer slot)
module hrr_rotate #(
    parameter int unsigned N    = 9,
    parameter int unsigned PW   = 4,
    parameter bit          UNDO = 1'b0
) (
    input  logic [PW-1:0] amt_i,
    input  logic [N-1:0]  vec_i,
    output logic [N-1:0]  vec_o
);
    import hrr_pkg::*;

    generate
        if (UNDO) begin : g_undo
            always_comb begin
                vec_o = '0;
                for (int k = 0; k < N; k++) begin
                    if (amt_i == PW'(k)) begin
                        for (int i = 0; i < N; i++) begin
                            vec_o[i] = vec_i[ring_sub(i, k, N)];
                        end
                    end
                end
            end
        end else begin : g_fwd
            always_comb begin
                vec_o = '0;
                for (int k = 0; k < N; k++) begin
                    if (amt_i == PW'(k)) begin
                        for (int i = 0; i < N; i++) begin
                            vec_o[i] = vec_i[ring_add(i, k, N)];
                        end
                    end
                end
            end
        end
    endgenerate

endmodule

// File: rtl/hrr_fixed_pick.sv
// Fixed-priority pick: lowest set bit wins.
module hrr_fixed_pick #(
    parameter int unsigned N = 9
) (
    input  logic [N-1:0] req_i,
    output logic [N-1:0] gnt_o
);
    logic [N:0] seen;

    assign seen[0] = 1'b0;

    generate
        for (genvar i = 0; i < N; i++) begin : g_bit
            assign gnt_o[i]   = req_i[i] & ~seen[i];
            assign seen[i+1]  = seen[i] | req_i[i];
        end
    endgenerate

endmodule

// File: rtl/hrr_onehot_enc.sv
// One-hot to index encoder, with a flag for "some bit set".
module hrr_onehot_enc #(
    parameter int unsigned N  = 9,
    parameter int unsigned PW = 4
) (
    input  logic [N-1:0]  onehot_i,
    output logic [PW-1:0] idx_o,
    output logic          any_o
);
    always_comb begin
        idx_o = '0;
        for (int i = 0; i < N; i++) begin
            if (onehot_i[i]) begin
                idx_o = idx_o | PW'(i);
            end
        end
    end

    assign any_o = |onehot_i;

endmodule

// File: rtl/hold_rr_arbiter.sv
module hold_rr_arbiter #(
    parameter int unsigned N = 9
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] req_i,
    output logic [N-1:0] gnt_o
);
    localparam int unsigned PW = hrr_pkg::ptr_width(N);

    typedef struct packed {
        logic [PW-1:0] ptr;
    } state_t;

    state_t        st_d, st_q;
    logic [PW-1:0] ptr_q;
    logic [N-1:0]  req_rot;
    logic [N-1:0]  gnt_rot;
    logic [PW-1:0] gnt_idx;
    logic          gnt_any;

    assign ptr_q = st_q.ptr;

    // Put the pointer slot at bit 0.
    hrr_rotate #(.N(N), .PW(PW), .UNDO(1'b0)) u_rot_fwd (
        .amt_i (ptr_q),
        .vec_i (req_i),
        .vec_o (req_rot)
    );

    hrr_fixed_pick #(.N(N)) u_pick (
        .req_i (req_rot),
        .gnt_o (gnt_rot)
    );

    // Return the winner to its own position.
    hrr_rotate #(.N(N), .PW(PW), .UNDO(1'b1)) u_rot_back (
        .amt_i (ptr_q),
        .vec_i (gnt_rot),
        .vec_o (gnt_o)
    );

    hrr_onehot_enc #(.N(N), .PW(PW)) u_enc (
        .onehot_i (gnt_o),
        .idx_o    (gnt_idx),
        .any_o    (gnt_any)
    );

    // Pointer follows the grantee; a held request keeps it in place,
    // a release lets the search continue past it; idle clears it.
    always_comb begin
        st_d = st_q;
        if (gnt_any) begin
            st_d.ptr = gnt_idx;
        end else begin
            st_d.ptr = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/hrr_hold_chk.sv
module hrr_hold_chk #(
    parameter int unsigned N  = 9,
    parameter int unsigned PW = 4
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic [N-1:0]  req_i,
    input logic [N-1:0]  gnt_o,
    input logic [PW-1:0] ptr_q
);
    // Set once a full cycle out of reset has been seen, so $past is meaningful.
    logic past_ok;
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            past_ok <= 1'b0;
        end else begin
            past_ok <= 1'b1;
        end
    end

    // R1
    one_hot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(gnt_o));

    // R2
    gnt_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (gnt_o & ~req_i) == '0);

    // R2
    busy_gnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|req_i) |-> (|gnt_o));

    // R5
    hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (past_ok && ((gnt_o & req_i) != '0)) |=> (gnt_o == $past(gnt_o)) || !(|($past(gnt_o) & req_i)));

    // R4
    ptr_track_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|gnt_o) |=> ((($past(gnt_o) >> ptr_q) & N'(1)) == N'(1)));

    // R7
    idle_ptr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(|req_i) |=> (ptr_q == '0));

    // R10
    ptr_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ptr_q < PW'(N));

endmodule

bind hold_rr_arbiter hrr_hold_chk #(.N(N), .PW(PW)) u_hold_chk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req_i),
    .gnt_o  (gnt_o),
    .ptr_q  (ptr_q)
);

// File: tb/test_hold_rr_arbiter.sv
module test_hold_rr_arbiter;
    localparam int unsigned N = 9;
    localparam logic [N-1:0] ALL = '1;

    logic         clk_i = 1'b0;
    logic         rst_ni = 1'b0;
    logic [N-1:0] req_i = '0;
    logic [N-1:0] gnt_o;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    hold_rr_arbiter #(.N(N)) i_hold_rr_arbiter (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .req_i  (req_i),
        .gnt_o  (gnt_o)
    );

    always #10 clk_i = ~clk_i;

    always @(posedge clk_i) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog: run hung, actual cycles=%0d expected<150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Circular first-set search from position p.
    function automatic logic [N-1:0] model(input logic [N-1:0] v, input int p);
        for (int k = 0; k < N; k++) begin
            if (v[(p + k) % N]) return N'(1) << ((p + k) % N);
        end
        return '0;
    endfunction

    // Advance to just after the next rising edge, then let logic settle.
    task automatic tick();
        @(posedge clk_i);
        #2;
    endtask

    task automatic check(input string req, input logic [N-1:0] exp);
        #3;
        checks++;
        if (gnt_o !== exp) begin
            failures++;
            $display("FAIL %s: gnt actual=%b expected=%b (req=%b)", req, gnt_o, exp, req_i);
        end
    endtask

    initial begin
        // R8: reset state
        rst_ni = 1'b0;
        req_i  = '0;
        tick(); tick();
        check("R8 idle in reset", '0);
        rst_ni = 1'b1;
        req_i  = N'(9'b100000100);
        check("R8 first arbitration from pointer 0", N'(9'b000000100));
        req_i  = '0;
        tick();

        // R3/R4/R7/R10: exhaustive sweep over pointer positions and vectors
        for (int p = 0; p < N; p++) begin
            for (int v = 0; v < (1 << N); v++) begin
                req_i = N'(1) << p;
                tick();
                req_i = N'(v);
                check("R3 circular pick", model(N'(v), p));
                tick();
                req_i = ALL;
                if (v == 0)
                    check("R7 pointer cleared after idle", N'(1));
                else
                    check("R4 pointer loaded with grantee", model(N'(v), p));
            end
        end

        // R5: holder keeps grant while others pile in
        req_i = '0;
        tick();
        req_i = N'(9'b000101000);
        check("R5 initial winner", N'(9'b000001000));
        tick();
        req_i = ALL;
        for (int c = 0; c < 6; c++) begin
            check("R5 grant held", N'(9'b000001000));
            tick();
        end
        // R6: release passes to next after former grantee
        req_i = ALL & ~N'(9'b000001000);
        check("R6 release to next", N'(9'b000010000));
        tick();
        req_i = N'(9'b000000110);
        check("R6 wrap past top", N'(9'b000000010));
        tick();

        // R7: idle returns pointer to 0 (held pointer 5 would pick 7)
        req_i = N'(9'b000100000);
        tick();
        req_i = '0;
        check("R7 idle grant zero", '0);
        tick();
        req_i = N'(9'b010000010);
        check("R7 pointer back at 0", N'(9'b000000010));
        tick();

        // R9/R10: full rotation with release after each grant
        req_i = '0;
        tick();
        req_i = ALL;
        for (int k = 0; k < 2 * N; k++) begin
            check("R9 turn order", N'(1) << (k % N));
            req_i = ALL & ~(N'(1) << (k % N));
            tick();
            req_i = ALL;
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule